// File: doc/BRIEF.md
# Framed Parallel Word Transmitter

This block is the sending end of a point-to-point parallel word bus. The bus has no address lines. It drives a 32-bit data bus, an active-low data-valid strobe and an active-low sync strobe, and all three are timed by the block's own free-running clock, which also serves as the bus word clock. Words arrive from upstream over a valid/ready stream, with a last-word flag that closes a transmission.

A transmission begins with a one-cycle start request. At that moment the block samples the mode input. In unframed mode the sync strobe stays high for the whole transmission and words flow at once. In single-frame mode the block first drives exactly one sync pulse, one clock wide. It then holds the bus idle for a fixed number of clocks (parameter `GAP_CYC`, at least 1) and only then starts accepting words. A receiver can therefore tell the start of a new transmission by the sync pulse alone. Inside a transmission, data-valid drops only in cycles that carry a word. Upstream stalls therefore show up as bus cycles with data-valid high.

Top module: `framed_word_tx`

## Requirements
- R1: During and after reset, `bus_sync_n` and `bus_dv_n` are high and `s_ready` is low until a start request is taken.
- R2: In a transmission started with `frame_mode` = 0 (unframed), `bus_sync_n` never goes low.
- R3: In a transmission started with `frame_mode` = 1 (single-frame), `bus_sync_n` is low for exactly one clock. That clock is the first cycle after the clock edge that takes the start request.
- R4: In single-frame mode, at least `GAP_CYC`+1 clocks with `bus_dv_n` high separate the sync pulse from the first clock with `bus_dv_n` low. `bus_dv_n` is never low while `bus_sync_n` is low.
- R5: `s_ready` is high only in the data phase. It is never high while sync is low, and never high during the idle gap that follows sync.
- R6: A word taken at a clock edge (`s_valid` and `s_ready` both high) appears on `bus_data` with `bus_dv_n` low for the following cycle. In every cycle after an edge that took no word, `bus_dv_n` is high. Words leave in the order they were taken.
- R7: Taking a word with `s_last` high ends the transmission: `s_ready` drops in the next cycle. A start request made while a transmission is in progress is ignored.
- R8: `frame_mode` is sampled only when a start request is taken while the block is idle. Changing it during a transmission does not alter that transmission.
- R9: Counting the cycle right after the edge that takes the start request as cycle 1, `s_ready` first rises in cycle 1 when unframed and in cycle `GAP_CYC`+2 when single-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running word clock; also the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_mode | input | 1 | 1 = single-frame, 0 = unframed; sampled with the start request |
| tx_start | input | 1 | Start-of-transmission request, taken only while idle |
| s_valid | input | 1 | Upstream word available |
| s_ready | output | 1 | Block takes the upstream word at this edge |
| s_data | input | DATA_W | Upstream word |
| s_last | input | 1 | Marks the final word of the transmission |
| bus_data | output | DATA_W | Parallel data bus |
| bus_dv_n | output | 1 | Active-low data-valid strobe |
| bus_sync_n | output | 1 | Active-low sync strobe |

## Verification
On every cycle, the assertions check the following: the sync pulse is one clock wide and happens only in single-frame transmissions; data-valid stays high through sync and the guard gap after it; ready never overlaps sync; each taken word appears on the bus one cycle later; and the latched mode stays stable while busy. Some properties are visible only in the bench's sweep over both modes, several transmission lengths and several stall patterns. These are the exact sync count per transmission, the exact cycle in which ready first rises, end-of-transmission on the last word, immunity to mid-transmission mode changes and start requests, and the in-order word stream.

// File: rtl/fwt_pkg.sv
package fwt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SYNC = 2'd1,
    ST_GAP  = 2'd2,
    ST_DATA = 2'd3
  } tx_state_e;

  // Cycle (1 = first cycle after the start edge) in which ready first rises.
  function automatic int unsigned first_ready_cycle(input bit framed, input int unsigned gap);
    return framed ? gap + 2 : 1;
  endfunction

  // Number of cycles after a sync pulse during which data-valid must stay high.
  function automatic int unsigned sync_guard(input int unsigned gap);
    return gap + 1;
  endfunction

endpackage

// File: rtl/fwt_seq.sv
module fwt_seq #(
  parameter int unsigned GAP_CYC = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_req,
  input  logic                mode_in,
  input  logic                accept,
  input  logic                accept_last,
  output fwt_pkg::tx_state_e  state_q,
  output logic                mode_q
);
  import fwt_pkg::*;

  localparam int unsigned CW = $clog2(GAP_CYC + 1) + 1;
  localparam logic [CW-1:0] GAP_LAST = CW'(GAP_CYC - 1);

  logic [CW-1:0] gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b0;
      gap_cnt <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_req) begin
            mode_q  <= mode_in;
            state_q <= mode_in ? ST_SYNC : ST_DATA;
          end
        end
        ST_SYNC: begin
          gap_cnt <= '0;
          state_q <= ST_GAP;
        end
        ST_GAP: begin
          if (gap_cnt == GAP_LAST) state_q <= ST_DATA;
          else                     gap_cnt <= gap_cnt + 1'b1;
        end
        default: begin
          if (accept && accept_last) state_q <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/fwt_outreg.sv
module fwt_outreg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [DATA_W-1:0] word_in,
  output logic [DATA_W-1:0] bus_word,
  output logic              dv_n
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_word <= '0;
      dv_n     <= 1'b1;
    end else begin
      dv_n <= ~take;
      if (take) bus_word <= word_in;
    end
  end

endmodule

// File: rtl/framed_word_tx.sv
module framed_word_tx #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned GAP_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_mode,
  input  logic              tx_start,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_last,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_dv_n,
  output logic              bus_sync_n
);
  import fwt_pkg::*;

  tx_state_e state_w;
  logic      mode_q_w;
  logic      sync_phase_w;
  logic      data_phase_w;
  logic      busy_w;
  logic      accept_w;

  fwt_seq #(.GAP_CYC(GAP_CYC)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_req   (tx_start),
    .mode_in     (frame_mode),
    .accept      (accept_w),
    .accept_last (s_last),
    .state_q     (state_w),
    .mode_q      (mode_q_w)
  );

  assign sync_phase_w = (state_w == ST_SYNC);
  assign data_phase_w = (state_w == ST_DATA);
  assign busy_w       = (state_w != ST_IDLE);
  assign accept_w     = s_valid && data_phase_w;

  assign s_ready    = data_phase_w;
  assign bus_sync_n = ~sync_phase_w;

  fwt_outreg #(.DATA_W(DATA_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (accept_w),
    .word_in  (s_data),
    .bus_word (bus_data),
    .dv_n     (bus_dv_n)
  );

endmodule

// File: rtl/fwt_checker.sv
module fwt_checker #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned GAP_CYC = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_valid,
  input logic              s_ready,
  input logic [DATA_W-1:0] s_data,
  input logic [DATA_W-1:0] bus_data,
  input logic              bus_dv_n,
  input logic              bus_sync_n,
  input logic              busy,
  input logic              mode_q
);
  import fwt_pkg::*;

  localparam int unsigned GUARD = sync_guard(GAP_CYC);
  localparam int unsigned KW    = $clog2(GUARD + 2) + 1;

  logic [KW-1:0] since_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_sync <= KW'(GUARD + 1);
    else if (!bus_sync_n)     since_sync <= '0;
    else if (since_sync <= KW'(GUARD)) since_sync <= since_sync + 1'b1;
  end

  initial begin
    assert_gap_param_R4: assert (GAP_CYC >= 1);
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (bus_sync_n && !s_ready));

  assert_no_sync_unframed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sync_n |-> mode_q);

  assert_sync_one_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sync_n |=> bus_sync_n);

  assert_dv_high_in_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sync_n |-> bus_dv_n);

  assert_dv_guard_after_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (since_sync < KW'(GUARD)) |-> bus_dv_n);

  assert_ready_not_in_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> bus_sync_n);

  assert_word_follows_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> (!bus_dv_n && bus_data == $past(s_data)));

  assert_dv_idle_without_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_valid && s_ready) |=> bus_dv_n);

  assert_mode_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mode_q));

endmodule

bind framed_word_tx fwt_checker #(.DATA_W(DATA_W), .GAP_CYC(GAP_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .s_valid    (s_valid),
  .s_ready    (s_ready),
  .s_data     (s_data),
  .bus_data   (bus_data),
  .bus_dv_n   (bus_dv_n),
  .bus_sync_n (bus_sync_n),
  .busy       (busy_w),
  .mode_q     (mode_q_w)
);

// File: tb/tb_framed_word_tx.sv
module tb_framed_word_tx;
  localparam int unsigned DW  = 32;
  localparam int unsigned GAP = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_mode = 1'b0;
  logic          tx_start = 1'b0;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic [DW-1:0] s_data = '0;
  logic          s_last = 1'b0;
  logic [DW-1:0] bus_data;
  logic          bus_dv_n;
  logic          bus_sync_n;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  framed_word_tx #(.DATA_W(DW), .GAP_CYC(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .frame_mode(frame_mode), .tx_start(tx_start),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .bus_data(bus_data), .bus_dv_n(bus_dv_n), .bus_sync_n(bus_sync_n)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] word_of(input int len, input int seed, input int i);
    return 32'hC3000000 ^ (DW'(len) << 16) ^ (DW'(seed) << 12) ^ (DW'(i) * 32'h00010101);
  endfunction

  // Own restatement of the latency: gap cycles plus sync plus one, or one.
  function automatic int ready_start(input bit framed);
    int r;
    r = 1;
    if (framed) r = 1 + 1 + GAP;
    return r;
  endfunction

  task automatic run_tx(input bit mode, input int len, input int seed, input bit flip, input bit extra);
    int  idx, got, syncs, sync_t, first_dv, ready_err, dv_err, data_err, tail;
    bit  acc_prev, take, v;
    idx = 0; got = 0; syncs = 0; sync_t = -1; first_dv = -1;
    ready_err = 0; dv_err = 0; data_err = 0; tail = 0; acc_prev = 0;
    @(negedge clk);
    frame_mode = mode;
    tx_start = 1'b1;
    s_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    tx_start = 1'b0;
    for (int t = 1; t < 400; t++) begin
      if (!bus_sync_n) begin syncs++; if (sync_t < 0) sync_t = t; end
      if (!bus_dv_n) begin
        if (!acc_prev) dv_err++;
        if (bus_data !== word_of(len, seed, got)) data_err++;
        if (first_dv < 0) first_dv = t;
        got++;
      end else if (acc_prev) dv_err++;
      if (s_ready !== ((t >= ready_start(mode)) && (idx < len))) ready_err++;
      frame_mode = flip && (t >= 2) ? ~mode : mode;
      tx_start = (extra && t == 3 && idx < len);
      v = (idx < len) && (seed == 0 || ((t + seed) % 3) != 0);
      s_valid = v;
      s_data = word_of(len, seed, idx);
      s_last = (idx == len - 1);
      take = v && s_ready;
      @(posedge clk);
      if (take) idx++;
      acc_prev = take;
      @(negedge clk);
      tx_start = 1'b0;
      s_valid = 1'b0;
      if (idx == len) tail++;
      if (tail > GAP + 4) break;
    end
    if (mode) begin
      check(syncs == 1, "R3 sync count single-frame", syncs, 1);
      check(sync_t == 1, "R3 sync cycle", sync_t, 1);
      check(first_dv - sync_t >= GAP + 2, "R4 sync to dv spacing", first_dv - sync_t, GAP + 2);
    end else begin
      check(syncs == 0, "R2 sync count unframed", syncs, 0);
    end
    check(ready_err == 0, "R5 R9 ready timing", ready_err, 0);
    check(dv_err == 0, "R6 dv follows take", dv_err, 0);
    check(data_err == 0, "R6 word order", data_err, 0);
    check(got == len, "R7 words per transmission", got, len);
    if (seed == 0)
      check(first_dv == ready_start(mode) + 1, "R9 first dv cycle", first_dv, ready_start(mode) + 1);
    if (flip)
      check(syncs == (mode ? 1 : 0), "R8 mode change mid-transmission", syncs, mode ? 1 : 0);
    if (extra)
      check(s_ready == 1'b0 && bus_sync_n == 1'b1, "R7 start while busy ignored", s_ready, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(bus_sync_n == 1'b1 && bus_dv_n == 1'b1 && s_ready == 1'b0, "R1 in reset", {bus_sync_n, bus_dv_n, s_ready}, 3'b110);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(bus_sync_n == 1'b1 && bus_dv_n == 1'b1 && s_ready == 1'b0, "R1 after reset", {bus_sync_n, bus_dv_n, s_ready}, 3'b110);
    for (int m = 0; m < 2; m++)
      for (int l = 1; l <= 5; l++)
        for (int s = 0; s < 3; s++)
          run_tx(m[0], l, s, (s == 1), (s == 2));
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

endmodule